// File: doc/BRIEF.md
# Two-Bit Switch Function-Command Processor

This block is the command layer of a serial-bus addressable switch with two logical devices. Each device runs once its address has been matched. A byte-level bus front end gives it received bytes through a valid strobe and takes bytes to transmit through a valid/ready handshake. The front end also signals each bus reset. Each device samples a nibble of pin-state inputs and holds a byte-wide output latch. The latch is all ones after power-up, which means every output is released.

A read command makes the device stream status bytes. Each status byte carries the pin nibble in its low half and the inverse of that nibble in its high half. A write command is protected: the value byte must be followed by its bitwise inverse. Only then does the latch take the value, and the device answers with a fixed confirmation code. Any failed check or unknown command sends the device into a mute state until the next bus reset.

Each device is a state machine with these states:
- `SW_WAIT_CMD`: waiting for a command byte.
- `SW_WAIT_VAL`: waiting for the value byte.
- `SW_WAIT_INV`: waiting for the inverted value byte.
- `SW_READ_STREAM`: sending status bytes.
- `SW_CONFIRM`: sending the confirmation code.
- `SW_POST_WRITE`: silent after a write.
- `SW_MUTE`: ignoring all traffic.

The transitions are:
- From `SW_WAIT_CMD`, byte 0xF5 goes to `SW_READ_STREAM`.
- From `SW_WAIT_CMD`, byte 0x5A goes to `SW_WAIT_VAL`.
- From `SW_WAIT_CMD`, any other byte goes to `SW_MUTE`.
- From `SW_WAIT_VAL`, any byte goes to `SW_WAIT_INV`.
- From `SW_WAIT_INV`, a matching inverse goes to `SW_CONFIRM`.
- From `SW_WAIT_INV`, a mismatch goes to `SW_MUTE`.
- From `SW_CONFIRM`, the accepted 0xAA goes to `SW_POST_WRITE`.
- From any state, a bus reset goes to `SW_WAIT_CMD`.

Top module: `switch_cmd_proc`

## Requirements
- R1: After global reset, every output latch reads 0xFF, no device offers a byte to transmit, and every device waits for a command.
- R2: Command 0xF5 makes the device offer a status byte in the next cycle. Bits 3:0 of that byte are the pin nibble sampled in the cycle the command was taken, and bits 7:4 are the bitwise inverse of that nibble.
- R3: While reading, each accepted status byte is replaced by a fresh one, sampled from the pins in the cycle of acceptance. This repeats without end until a bus reset.
- R4: After command 0x5A, the next byte is held as the pending value. The byte after that is inverted and compared with the pending value, and only on an exact match is the pending value written to the latch.
- R5: After a successful write, the device offers 0xAA once. It then offers nothing and ignores received bytes until a bus reset.
- R6: If the inverted byte does not match, the latch keeps its value and the device ignores all traffic until a bus reset.
- R7: A command byte other than 0xF5 or 0x5A makes the device ignore all traffic until a bus reset.
- R8: A bus reset returns the device to waiting for a command and clears the pending value, but leaves the latch unchanged. A bus reset wins over a byte received in the same cycle.
- R9: The devices decode identically and never change each other's latch, pending value or state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low |
| bus_reset | input | N_DEV | Per-device bus reset pulse |
| rx_valid | input | N_DEV | Per-device received-byte strobe |
| rx_data | input | N_DEV*8 | Received bytes, device d in bits 8d+7:8d |
| tx_ready | input | N_DEV | Front end accepts the offered byte |
| pin_state | input | N_DEV*4 | Sampled pin nibbles, device d in bits 4d+3:4d |
| tx_valid | output | N_DEV | Device offers a byte |
| tx_data | output | N_DEV*8 | Offered bytes |
| latch_q | output | N_DEV*8 | Output latch of each device |

## Verification
The bench changes the pins between loading a status byte and accepting it. A design that samples at the wrong time shows the new nibble a byte too early, or repeats a stale one. Valid writes, a wrong inverse and an unknown command are each followed by a read command. A device that failed to go mute would answer that read, and a latch written without the check would show the bad value. A bus reset is given together with a write command and after a half-finished write. A design without reset priority, or one that keeps its mode across a reset, would miss the following read. The second device is driven while the first is mid-read, and its latch is checked, to catch any state shared between the devices.

// File: rtl/swc_pkg.sv
package swc_pkg;
    typedef enum logic [2:0] {
        SW_WAIT_CMD,
        SW_WAIT_VAL,
        SW_WAIT_INV,
        SW_READ_STREAM,
        SW_CONFIRM,
        SW_POST_WRITE,
        SW_MUTE
    } swc_state_e;

    localparam logic [7:0] CMD_READ     = 8'hF5;
    localparam logic [7:0] CMD_WRITE    = 8'h5A;
    localparam logic [7:0] CONFIRM_CODE = 8'hAA;
endpackage

// File: rtl/swc_cmd_decode.sv
module swc_cmd_decode
    import swc_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] code,
    output logic              is_read,
    output logic              is_write
);
    always_comb begin
        is_read  = (code == BYTE_W'(CMD_READ));
        is_write = (code == BYTE_W'(CMD_WRITE));
    end
endmodule

// File: rtl/swc_status_reg.sv
module swc_status_reg #(
    parameter int PIN_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PIN_W-1:0]   pins,
    output logic [2*PIN_W-1:0] status_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (load) begin
            status_q <= {~pins, pins};
        end
    end
endmodule

// File: rtl/swc_channel.sv
module swc_channel
    import swc_pkg::*;
#(
    parameter int PIN_W = 4,
    localparam int BYTE_W = 2 * PIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              tx_ready,
    input  logic [PIN_W-1:0]  pins,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic [BYTE_W-1:0] latch_q
);
    swc_state_e        state_q, state_d;
    logic [BYTE_W-1:0] pending_q;
    logic [BYTE_W-1:0] status_q;
    logic              is_read, is_write;
    logic              inv_match;
    logic              take_rx;
    logic              status_load;
    logic              write_fire;

    swc_cmd_decode #(.BYTE_W(BYTE_W)) u_dec (
        .code     (rx_data),
        .is_read  (is_read),
        .is_write (is_write)
    );

    assign take_rx     = rx_valid && !bus_reset;
    assign inv_match   = ((~rx_data) == pending_q);
    assign write_fire  = take_rx && (state_q == SW_WAIT_INV) && inv_match;
    assign status_load = !bus_reset &&
                         (((state_q == SW_WAIT_CMD) && rx_valid && is_read) ||
                          ((state_q == SW_READ_STREAM) && tx_ready));

    swc_status_reg #(.PIN_W(PIN_W)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (status_load),
        .pins     (pins),
        .status_q (status_q)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (bus_reset) begin
            state_d = SW_WAIT_CMD;
        end else begin
            unique case (state_q)
                SW_WAIT_CMD: begin
                    if (rx_valid) begin
                        if (is_read)       state_d = SW_READ_STREAM;
                        else if (is_write) state_d = SW_WAIT_VAL;
                        else               state_d = SW_MUTE;
                    end
                end
                SW_WAIT_VAL: begin
                    if (rx_valid) state_d = SW_WAIT_INV;
                end
                SW_WAIT_INV: begin
                    if (rx_valid) state_d = inv_match ? SW_CONFIRM : SW_MUTE;
                end
                SW_READ_STREAM: state_d = SW_READ_STREAM;
                SW_CONFIRM: begin
                    if (tx_ready) state_d = SW_POST_WRITE;
                end
                SW_POST_WRITE: state_d = SW_POST_WRITE;
                SW_MUTE:       state_d = SW_MUTE;
                default:       state_d = SW_MUTE;
            endcase
        end
    end

    // state, pending value and latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= SW_WAIT_CMD;
            pending_q <= '0;
            latch_q   <= '1;
        end else begin
            state_q <= state_d;
            if (bus_reset) begin
                pending_q <= '0;
            end else if (take_rx && state_q == SW_WAIT_VAL) begin
                pending_q <= rx_data;
            end
            if (write_fire) begin
                latch_q <= pending_q;
            end
        end
    end

    // outputs
    always_comb begin
        tx_valid = 1'b0;
        tx_data  = '0;
        unique case (state_q)
            SW_READ_STREAM: begin
                tx_valid = 1'b1;
                tx_data  = status_q;
            end
            SW_CONFIRM: begin
                tx_valid = 1'b1;
                tx_data  = BYTE_W'(CONFIRM_CODE);
            end
            default: begin
                tx_valid = 1'b0;
                tx_data  = '0;
            end
        endcase
    end

    assert_status_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_READ_STREAM) |->
            (tx_valid && (tx_data[BYTE_W-1:PIN_W] == ~tx_data[PIN_W-1:0])));

    assert_read_persists_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_READ_STREAM && !bus_reset) |=> (state_q == SW_READ_STREAM));

    assert_latch_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(latch_q) |-> ($past(state_q) == SW_WAIT_INV));

    assert_confirm_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_CONFIRM) |-> (tx_valid && tx_data == BYTE_W'(CONFIRM_CODE)));

    assert_post_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_POST_WRITE) |-> !tx_valid);

    assert_mute_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_MUTE && !bus_reset) |=>
            (state_q == SW_MUTE && $stable(latch_q) && !tx_valid));

    assert_bus_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (state_q == SW_WAIT_CMD && pending_q == '0 && $stable(latch_q)));
endmodule

// File: rtl/switch_cmd_proc.sv
module switch_cmd_proc #(
    parameter int N_DEV = 2,
    parameter int PIN_W = 4,
    localparam int BYTE_W = 2 * PIN_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_DEV-1:0]        bus_reset,
    input  logic [N_DEV-1:0]        rx_valid,
    input  logic [N_DEV*BYTE_W-1:0] rx_data,
    input  logic [N_DEV-1:0]        tx_ready,
    input  logic [N_DEV*PIN_W-1:0]  pin_state,
    output logic [N_DEV-1:0]        tx_valid,
    output logic [N_DEV*BYTE_W-1:0] tx_data,
    output logic [N_DEV*BYTE_W-1:0] latch_q
);
    for (genvar d = 0; d < N_DEV; d++) begin : g_dev
        swc_channel #(.PIN_W(PIN_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_reset (bus_reset[d]),
            .rx_valid  (rx_valid[d]),
            .rx_data   (rx_data[d*BYTE_W +: BYTE_W]),
            .tx_ready  (tx_ready[d]),
            .pins      (pin_state[d*PIN_W +: PIN_W]),
            .tx_valid  (tx_valid[d]),
            .tx_data   (tx_data[d*BYTE_W +: BYTE_W]),
            .latch_q   (latch_q[d*BYTE_W +: BYTE_W])
        );
    end
endmodule

// File: tb/switch_cmd_proc_bench.sv
module switch_cmd_proc_bench;
    localparam int N_DEV = 2;
    localparam logic [2:0] OP_PIN = 3'd0, OP_RXB = 3'd1, OP_TXP = 3'd2,
                           OP_LAT = 3'd3, OP_NOTX = 3'd4, OP_BRS = 3'd5;
    localparam int NV = 48;
    // fields: op[23:21] dev[20] data[19:12] expect[11:4] requirement[3:0]
    localparam logic [23:0] VEC [NV] = '{
        {OP_PIN, 1'b0, 8'h05, 8'h00, 4'd2},  // R2 pins 5
        {OP_RXB, 1'b0, 8'hF5, 8'h00, 4'd2},  // R2 read command
        {OP_PIN, 1'b0, 8'h03, 8'h00, 4'd3},  // R3 pins change after load
        {OP_TXP, 1'b0, 8'h00, 8'hA5, 4'd2},  // R2 first status
        {OP_TXP, 1'b0, 8'h00, 8'hC3, 4'd3},  // R3 resampled
        {OP_TXP, 1'b0, 8'h00, 8'hC3, 4'd3},  // R3 repeats
        {OP_BRS, 1'b0, 8'h00, 8'h00, 4'd8},
        {OP_NOTX,1'b0, 8'h00, 8'h00, 4'd8},  // R8 read ended
        {OP_LAT, 1'b0, 8'h00, 8'hFF, 4'd8},
        {OP_RXB, 1'b0, 8'h5A, 8'h00, 4'd4},  // R4 write
        {OP_RXB, 1'b0, 8'h12, 8'h00, 4'd4},
        {OP_RXB, 1'b0, 8'hED, 8'h00, 4'd4},
        {OP_TXP, 1'b0, 8'h00, 8'hAA, 4'd5},  // R5 confirm
        {OP_NOTX,1'b0, 8'h00, 8'h00, 4'd5},
        {OP_LAT, 1'b0, 8'h00, 8'h12, 4'd4},
        {OP_RXB, 1'b0, 8'hF5, 8'h00, 4'd5},  // R5 ignored after write
        {OP_NOTX,1'b0, 8'h00, 8'h00, 4'd5},
        {OP_LAT, 1'b1, 8'h00, 8'hFF, 4'd9},  // R9 other latch untouched
        {OP_BRS, 1'b0, 8'h00, 8'h00, 4'd6},
        {OP_RXB, 1'b0, 8'h5A, 8'h00, 4'd6},  // R6 bad inverse
        {OP_RXB, 1'b0, 8'h34, 8'h00, 4'd6},
        {OP_RXB, 1'b0, 8'h34, 8'h00, 4'd6},
        {OP_NOTX,1'b0, 8'h00, 8'h00, 4'd6},
        {OP_LAT, 1'b0, 8'h00, 8'h12, 4'd6},
        {OP_RXB, 1'b0, 8'hF5, 8'h00, 4'd6},
        {OP_NOTX,1'b0, 8'h00, 8'h00, 4'd6},
        {OP_BRS, 1'b0, 8'h00, 8'h00, 4'd7},
        {OP_RXB, 1'b0, 8'h77, 8'h00, 4'd7},  // R7 unknown command
        {OP_RXB, 1'b0, 8'hF5, 8'h00, 4'd7},
        {OP_NOTX,1'b0, 8'h00, 8'h00, 4'd7},
        {OP_BRS, 1'b0, 8'h00, 8'h00, 4'd8},
        {OP_RXB, 1'b0, 8'h5A, 8'h00, 4'd8},  // R8 half write then reset
        {OP_RXB, 1'b0, 8'h40, 8'h00, 4'd8},
        {OP_BRS, 1'b0, 8'h00, 8'h00, 4'd8},
        {OP_RXB, 1'b0, 8'hF5, 8'h00, 4'd8},
        {OP_TXP, 1'b0, 8'h00, 8'hC3, 4'd8},
        {OP_LAT, 1'b0, 8'h00, 8'h12, 4'd8},
        {OP_PIN, 1'b1, 8'h0A, 8'h00, 4'd9},
        {OP_RXB, 1'b1, 8'h5A, 8'h00, 4'd9},  // R9 device 1 write
        {OP_RXB, 1'b1, 8'h01, 8'h00, 4'd9},
        {OP_TXP, 1'b0, 8'h00, 8'hC3, 4'd9},  // R9 device 0 still reading
        {OP_RXB, 1'b1, 8'hFE, 8'h00, 4'd9},
        {OP_TXP, 1'b1, 8'h00, 8'hAA, 4'd9},
        {OP_LAT, 1'b1, 8'h00, 8'h01, 4'd9},
        {OP_LAT, 1'b0, 8'h00, 8'h12, 4'd9},
        {OP_BRS, 1'b1, 8'h00, 8'h00, 4'd9},
        {OP_RXB, 1'b1, 8'hF5, 8'h00, 4'd2},
        {OP_TXP, 1'b1, 8'h00, 8'h5A, 4'd2}   // R2 device 1 status
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N_DEV-1:0]     bus_reset = '0;
    logic [N_DEV-1:0]     rx_valid = '0;
    logic [N_DEV*8-1:0]   rx_data = '0;
    logic [N_DEV-1:0]     tx_ready = '0;
    logic [N_DEV*4-1:0]   pin_state = '0;
    logic [N_DEV-1:0]     tx_valid;
    logic [N_DEV*8-1:0]   tx_data;
    logic [N_DEV*8-1:0]   latch_q;
    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    switch_cmd_proc #(.N_DEV(N_DEV), .PIN_W(4)) u_switch_cmd_proc (
        .clk, .rst_n, .bus_reset, .rx_valid, .rx_data, .tx_ready,
        .pin_state, .tx_valid, .tx_data, .latch_q
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rx_byte(input int d, input logic [7:0] b);
        rx_valid[d] = 1'b1;
        rx_data[d*8 +: 8] = b;
        @(posedge clk);
        @(negedge clk);
        rx_valid[d] = 1'b0;
    endtask

    task automatic pulse_bus_reset(input int d);
        bus_reset[d] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_reset[d] = 1'b0;
    endtask

    task automatic pull(input int d, input logic [7:0] exp, input string req);
        check(req, {7'd0, tx_valid[d]}, 8'd1);
        check(req, tx_data[d*8 +: 8], exp);
        tx_ready[d] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_ready[d] = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1", latch_q[7:0], 8'hFF);
        check("R1", latch_q[15:8], 8'hFF);
        check("R1", {6'd0, tx_valid}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            automatic logic [2:0] op  = VEC[i][23:21];
            automatic int         d   = int'(VEC[i][20]);
            automatic logic [7:0] dat = VEC[i][19:12];
            automatic logic [7:0] exp = VEC[i][11:4];
            automatic string      req = $sformatf("R%0d vec %0d", VEC[i][3:0], i);
            case (op)
                OP_PIN:  pin_state[d*4 +: 4] = dat[3:0];
                OP_RXB:  rx_byte(d, dat);
                OP_TXP:  pull(d, exp, req);
                OP_LAT:  check(req, latch_q[d*8 +: 8], exp);
                OP_NOTX: check(req, {7'd0, tx_valid[d]}, 8'd0);
                OP_BRS:  pulse_bus_reset(d);
                default: ;
            endcase
        end
        // R8 bus reset wins over a write command in the same cycle
        pulse_bus_reset(0);
        bus_reset[0] = 1'b1;
        rx_byte(0, 8'h5A);
        bus_reset[0] = 1'b0;
        rx_byte(0, 8'hF5);
        pull(0, 8'hC3, "R8 priority");
        // R1 global reset restores released latches
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 rerun", latch_q[7:0], 8'hFF);
        check("R1 rerun", latch_q[15:8], 8'hFF);
        check("R1 rerun", {6'd0, tx_valid}, 8'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule